// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block decides where a 16-bit processor fetches next. Each cycle it takes the class of the instruction in flight, a 3-bit comparison selector, two general-register operands, a signed offset field and the current program counter. From these it produces the next program counter and a register write-back. There are no flags: every conditional branch compares the two registers directly.

Four instruction classes are handled. An ordinary instruction advances the PC by two bytes. A conditional branch adds the sign-extended offset to the PC when its comparison holds and advances by two when it does not. An immediate jump always adds the offset. A register jump exchanges the PC with register A: the PC takes the register value, and the old PC is sent back to be written into that same register. All outputs are registered, so the result for the inputs seen at one rising edge appears just after that edge and holds for one cycle.

Top module: `npc_unit`

## Requirements
- R1: Comparison selector 0 (equal) is true when operand A equals operand B; selector 1 (not equal) is true when they differ.
- R2: Selector 2 (test) is true when the bitwise AND of A and B is nonzero; selector 3 (test-not) is true when that AND is zero.
- R3: Selector 4 compares A less than B as signed two's-complement 16-bit values.
- R4: Selector 5 compares A less than B as unsigned 16-bit values.
- R5: Selectors 6 and 7 always evaluate as false, so a branch with either never redirects.
- R6: A conditional branch (class 1) whose comparison holds, and an immediate jump (class 2) regardless of the selector, give next PC = PC + offset, the OFF_W-bit offset sign-extended to 16 bits and the sum wrapping modulo 2^16; redirect_o is 1.
- R7: A sequential instruction (class 0) or a conditional branch whose comparison fails gives next PC = PC + 2, wrapping modulo 2^16, with redirect_o at 0.
- R8: A register jump (class 3) gives next PC = operand A, raises wb_en_o and puts the old PC on wb_data_o in the same cycle; redirect_o is 1.
- R9: wb_en_o is 0 for every class other than 3.
- R10: Outputs appear one clock after the inputs are sampled; while rst is high at a rising edge the outputs become next PC = RESET_PC (default 0), redirect_o = 0, wb_en_o = 0, wb_data_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cls_i | input | 2 | Instruction class: 0 sequential, 1 conditional branch, 2 immediate jump, 3 register jump |
| cond_i | input | 3 | Comparison selector, codes 0..7 |
| opa_i | input | 16 | Register operand A (also the register-jump target) |
| opb_i | input | 16 | Register operand B |
| off_i | input | OFF_W | Signed offset field |
| pc_i | input | 16 | Current program counter |
| next_pc_o | output | 16 | Registered next program counter |
| redirect_o | output | 1 | Registered: next PC is not the sequential one |
| wb_en_o | output | 1 | Registered: write wb_data_o back into register A |
| wb_data_o | output | 16 | Registered old PC for the register jump |

## Verification
The checker assumes that cls_i, cond_i and the operands are known (no X) at every rising edge after reset, and it compares each registered output with the inputs of the previous edge, so it also assumes the inputs are held stable across the sampling edge. The bench changes inputs only on falling edges and keeps them steady through the following rising edge, then samples one nanosecond after that edge. Operand values are chosen to sit on the boundaries where signed and unsigned ordering disagree, and offsets and PCs are chosen so the sums wrap in both directions.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int DATA_W  = 16;
    localparam int PC_STEP = 2;

    typedef enum logic [1:0] {
        CLS_SEQ  = 2'd0,
        CLS_BR   = 2'd1,
        CLS_JIMM = 2'd2,
        CLS_JREG = 2'd3
    } cls_e;

    typedef enum logic [2:0] {
        CMP_EQ   = 3'd0,
        CMP_NE   = 3'd1,
        CMP_TST  = 3'd2,
        CMP_TSTN = 3'd3,
        CMP_SLT  = 3'd4,
        CMP_ULT  = 3'd5,
        CMP_RSV6 = 3'd6,
        CMP_RSV7 = 3'd7
    } cmp_e;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        word_t next_pc;
        logic  redirect;
        logic  wb_en;
        word_t wb_data;
    } npc_res_t;

    function automatic word_t pc_advance(input word_t pc);
        return pc + word_t'(PC_STEP);
    endfunction

endpackage

// File: rtl/npc_cmp.sv
module npc_cmp
    import npc_pkg::*;
(
    input  cmp_e  sel_i,
    input  word_t a_i,
    input  word_t b_i,
    output logic  hit_o
);
    logic eq_w;
    logic anz_w;
    logic slt_w;
    logic ult_w;

    always_comb begin
        eq_w  = (a_i == b_i);
        anz_w = |(a_i & b_i);
        slt_w = ($signed(a_i) < $signed(b_i));
        ult_w = (a_i < b_i);
    end

    always_comb begin
        unique case (sel_i)
            CMP_EQ:   hit_o = eq_w;
            CMP_NE:   hit_o = !eq_w;
            CMP_TST:  hit_o = anz_w;
            CMP_TSTN: hit_o = !anz_w;
            CMP_SLT:  hit_o = slt_w;
            CMP_ULT:  hit_o = ult_w;
            default:  hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int OFF_W = 10
) (
    input  word_t            pc_i,
    input  logic [OFF_W-1:0] off_i,
    output word_t            seq_o,
    output word_t            rel_o
);
    localparam int EXT_W = DATA_W - OFF_W;

    word_t off_x;

    generate
        if (EXT_W > 0) begin : g_ext
            assign off_x = {{EXT_W{off_i[OFF_W-1]}}, off_i};
        end else begin : g_trunc
            assign off_x = off_i[DATA_W-1:0];
        end
    endgenerate

    assign seq_o = pc_advance(pc_i);
    assign rel_o = pc_i + off_x;
endmodule

// File: rtl/npc_sel.sv
module npc_sel
    import npc_pkg::*;
(
    input  cls_e     cls_i,
    input  logic     hit_i,
    input  word_t    pc_i,
    input  word_t    opa_i,
    input  word_t    seq_i,
    input  word_t    rel_i,
    output npc_res_t res_o
);
    always_comb begin
        res_o          = '0;
        res_o.next_pc  = seq_i;
        unique case (cls_i)
            CLS_SEQ: ;
            CLS_BR: begin
                if (hit_i) begin
                    res_o.next_pc  = rel_i;
                    res_o.redirect = 1'b1;
                end
            end
            CLS_JIMM: begin
                res_o.next_pc  = rel_i;
                res_o.redirect = 1'b1;
            end
            CLS_JREG: begin
                res_o.next_pc  = opa_i;
                res_o.redirect = 1'b1;
                res_o.wb_en    = 1'b1;
                res_o.wb_data  = pc_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int           OFF_W    = 10,
    parameter logic [15:0]  RESET_PC = 16'h0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cls_i,
    input  logic [2:0]       cond_i,
    input  logic [15:0]      opa_i,
    input  logic [15:0]      opb_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [15:0]      pc_i,
    output logic [15:0]      next_pc_o,
    output logic             redirect_o,
    output logic             wb_en_o,
    output logic [15:0]      wb_data_o
);
    logic     hit_w;
    word_t    seq_w;
    word_t    rel_w;
    npc_res_t res_w;
    npc_res_t res_q;

    npc_cmp u_cmp (
        .sel_i (cmp_e'(cond_i)),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .hit_o (hit_w)
    );

    npc_target #(.OFF_W(OFF_W)) u_tgt (
        .pc_i  (pc_i),
        .off_i (off_i),
        .seq_o (seq_w),
        .rel_o (rel_w)
    );

    npc_sel u_sel (
        .cls_i (cls_e'(cls_i)),
        .hit_i (hit_w),
        .pc_i  (pc_i),
        .opa_i (opa_i),
        .seq_i (seq_w),
        .rel_i (rel_w),
        .res_o (res_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q         <= '0;
            res_q.next_pc <= RESET_PC;
        end else begin
            res_q <= res_w;
        end
    end

    assign next_pc_o  = res_q.next_pc;
    assign redirect_o = res_q.redirect;
    assign wb_en_o    = res_q.wb_en;
    assign wb_data_o  = res_q.wb_data;
endmodule

// File: rtl/npc_checker.sv
module npc_checker #(
    parameter int OFF_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cls_i,
    input logic [2:0]       cond_i,
    input logic [15:0]      opa_i,
    input logic [15:0]      opb_i,
    input logic [OFF_W-1:0] off_i,
    input logic [15:0]      pc_i,
    input logic [15:0]      next_pc_o,
    input logic             redirect_o,
    input logic             wb_en_o,
    input logic [15:0]      wb_data_o
);
    AST_EQ_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'd1 && cond_i == 3'd0) |=> (redirect_o == ($past(opa_i) == $past(opb_i)))); // R1

    AST_TEST_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'd1 && cond_i == 3'd2) |=> (redirect_o == ($past(opa_i & opb_i) != 16'd0))); // R2

    AST_SLT_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'd1 && cond_i == 3'd4) |=> (redirect_o == ($signed($past(opa_i)) < $signed($past(opb_i))))); // R3

    AST_ULT_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'd1 && cond_i == 3'd5) |=> (redirect_o == ($past(opa_i) < $past(opb_i)))); // R4

    AST_RSV_FALSE: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'd1 && cond_i[2:1] == 2'b11) |=> !redirect_o); // R5

    AST_JIMM_TARGET: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'd2) |=> (redirect_o && next_pc_o == 16'($past(pc_i) + 16'($signed($past(off_i)))))); // R6

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'd0) |=> (!redirect_o && next_pc_o == 16'($past(pc_i) + 16'd2))); // R7

    AST_JREG_SWAP: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'd3) |=> (wb_en_o && redirect_o && next_pc_o == $past(opa_i) && wb_data_o == $past(pc_i))); // R8

    AST_NO_STRAY_WB: assert property (@(posedge clk) disable iff (rst)
        (cls_i != 2'd3) |=> !wb_en_o); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!redirect_o && !wb_en_o && wb_data_o == 16'd0)); // R10
endmodule

bind npc_unit npc_checker #(.OFF_W(OFF_W)) u_npc_chk (
    .clk        (clk),
    .rst        (rst),
    .cls_i      (cls_i),
    .cond_i     (cond_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .off_i      (off_i),
    .pc_i       (pc_i),
    .next_pc_o  (next_pc_o),
    .redirect_o (redirect_o),
    .wb_en_o    (wb_en_o),
    .wb_data_o  (wb_data_o)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
    localparam int OFF_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cls_i = '0;
    logic [2:0]       cond_i = '0;
    logic [15:0]      opa_i = '0;
    logic [15:0]      opb_i = '0;
    logic [OFF_W-1:0] off_i = '0;
    logic [15:0]      pc_i = '0;
    logic [15:0]      next_pc_o;
    logic             redirect_o;
    logic             wb_en_o;
    logic [15:0]      wb_data_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    npc_unit #(.OFF_W(OFF_W)) u0 (
        .clk(clk), .rst(rst), .cls_i(cls_i), .cond_i(cond_i),
        .opa_i(opa_i), .opb_i(opb_i), .off_i(off_i), .pc_i(pc_i),
        .next_pc_o(next_pc_o), .redirect_o(redirect_o),
        .wb_en_o(wb_en_o), .wb_data_o(wb_data_o)
    );

    function automatic bit ref_cond(input logic [2:0] c, input logic [15:0] a, input logic [15:0] b);
        case (c)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return (a & b) != 0;
            3'd3: return (a & b) == 0;
            3'd4: return $signed(a) < $signed(b);
            3'd5: return a < b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [1:0] cl, input logic [2:0] cd,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic [OFF_W-1:0] off, input logic [15:0] pc);
        logic [15:0] sx;
        logic [15:0] e_pc;
        bit e_red;
        bit e_wb;
        logic [15:0] e_wd;
        sx = {{(16-OFF_W){off[OFF_W-1]}}, off};
        e_red = 1'b0; e_wb = 1'b0; e_wd = 16'd0;
        e_pc = pc + 16'd2;
        if (cl == 2'd1 && ref_cond(cd, a, b)) begin e_pc = pc + sx; e_red = 1'b1; end
        if (cl == 2'd2) begin e_pc = pc + sx; e_red = 1'b1; end
        if (cl == 2'd3) begin e_pc = a; e_red = 1'b1; e_wb = 1'b1; e_wd = pc; end
        @(negedge clk);
        cls_i = cl; cond_i = cd; opa_i = a; opb_i = b; off_i = off; pc_i = pc;
        @(posedge clk);
        #1;
        chk({tag, " next_pc"}, next_pc_o, e_pc);
        chk({tag, " redirect"}, {15'd0, redirect_o}, {15'd0, e_red});
        chk({tag, " wb_en"}, {15'd0, wb_en_o}, {15'd0, e_wb});
        chk({tag, " wb_data"}, wb_data_o, e_wd);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        cls_i = 2'd2; off_i = 10'h3F; pc_i = 16'h1234;
        @(posedge clk); #1;
        chk("R10 reset next_pc", next_pc_o, 16'h0000);
        chk("R10 reset redirect", {15'd0, redirect_o}, 16'd0);
        chk("R10 reset wb_en", {15'd0, wb_en_o}, 16'd0);
        chk("R10 reset wb_data", wb_data_o, 16'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_equal;
        step("R1 eq hit",   2'd1, 3'd0, 16'hBEEF, 16'hBEEF, 10'd8, 16'h0100);
        step("R1 eq miss",  2'd1, 3'd0, 16'hBEEF, 16'hBEEE, 10'd8, 16'h0100);
        step("R1 ne hit",   2'd1, 3'd1, 16'h0001, 16'h8001, 10'd8, 16'h0100);
        step("R1 ne miss",  2'd1, 3'd1, 16'h7777, 16'h7777, 10'd8, 16'h0100);
    endtask

    task automatic t_test;
        step("R2 tst hit",   2'd1, 3'd2, 16'h8000, 16'hF000, 10'h3FC, 16'h0200);
        step("R2 tst miss",  2'd1, 3'd2, 16'h00F0, 16'h0F0F, 10'h3FC, 16'h0200);
        step("R2 tstn hit",  2'd1, 3'd3, 16'h00F0, 16'h0F0F, 10'h3FC, 16'h0200);
        step("R2 tstn miss", 2'd1, 3'd3, 16'h0001, 16'h0001, 10'h3FC, 16'h0200);
    endtask

    task automatic t_signed;
        step("R3 slt neg<pos",   2'd1, 3'd4, 16'h8000, 16'h0001, 10'd20, 16'h0300);
        step("R3 slt pos!<neg",  2'd1, 3'd4, 16'h0001, 16'hFFFF, 10'd20, 16'h0300);
        step("R3 slt equal",     2'd1, 3'd4, 16'hFFFE, 16'hFFFE, 10'd20, 16'h0300);
    endtask

    task automatic t_unsigned;
        step("R4 ult small<big", 2'd1, 3'd5, 16'h0001, 16'hFFFF, 10'd20, 16'h0300);
        step("R4 ult big!<small",2'd1, 3'd5, 16'h8000, 16'h0001, 10'd20, 16'h0300);
        step("R4 ult equal",     2'd1, 3'd5, 16'h4000, 16'h4000, 10'd20, 16'h0300);
    endtask

    task automatic t_unused;
        step("R5 code6", 2'd1, 3'd6, 16'h0000, 16'h0000, 10'd40, 16'h0400);
        step("R5 code7", 2'd1, 3'd7, 16'h0000, 16'hFFFF, 10'd40, 16'h0400);
    endtask

    task automatic t_jump;
        step("R6 jimm fwd",       2'd2, 3'd7, 16'h0, 16'h1, 10'h1FF, 16'h1000);
        step("R6 jimm back",      2'd2, 3'd0, 16'h0, 16'h1, 10'h200, 16'h1000);
        step("R6 jimm wrap up",   2'd2, 3'd6, 16'h0, 16'h0, 10'd16,  16'hFFF8);
        step("R6 jimm wrap down", 2'd2, 3'd0, 16'h0, 16'h0, 10'h3F0, 16'h0004);
        step("R6 branch back",    2'd1, 3'd0, 16'h5, 16'h5, 10'h3FE, 16'h0010);
    endtask

    task automatic t_seq;
        step("R7 seq",      2'd0, 3'd0, 16'h1, 16'h1, 10'd100, 16'h2000);
        step("R7 seq wrap", 2'd0, 3'd1, 16'h1, 16'h2, 10'd100, 16'hFFFE);
        step("R7 br miss wrap", 2'd1, 3'd1, 16'h3, 16'h3, 10'd100, 16'hFFFE);
    endtask

    task automatic t_regjump;
        step("R8 jreg",     2'd3, 3'd5, 16'hA5A4, 16'h0000, 10'd2, 16'h0C00);
        step("R8 jreg odd", 2'd3, 3'd7, 16'h0001, 16'hFFFF, 10'h3FF, 16'hFFFE);
        step("R9 after jreg seq", 2'd0, 3'd0, 16'hA5A4, 16'h0, 10'd2, 16'hA5A4);
        step("R9 jimm no wb",     2'd2, 3'd0, 16'hA5A4, 16'h0, 10'd2, 16'hA5A6);
    endtask

    initial begin
        t_reset();
        t_equal();
        t_test();
        t_signed();
        t_unsigned();
        t_unused();
        t_jump();
        t_seq();
        t_regjump();
        t_reset();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule